// File: doc/BRIEF.md
# P-Persistent Channel Access Arbiter

This block decides the moment a half-duplex radio port may key up and send a queued frame. A slow periodic tick, nominally every 10 ms, paces it. On each tick, when the port is enabled, the transmitter is idle and a frame waits, the block looks at the carrier-detect input. It counts down a slot counter while the channel is clear. When the counter expires, it draws a pseudo-random byte and compares it with a persistence threshold. The result is a single-cycle `start_tx` pulse, which the transmit sequencer consumes.

In full-duplex mode the channel check is bypassed, so a waiting frame is started on the next tick. The slot time is held in milliseconds and the persistence threshold is a byte. Each has a write strobe. A slot-time write reloads the slot counter at once. The random source is a free-running 16-bit LFSR inside the block.

Top module: `ppa_arbiter`

## Requirements
- R1: `start_tx` rises only in the cycle after a clock edge that sampled `tick`, `enable`, `tx_idle` and `frame_pending` all high. It lasts one cycle per qualifying tick.
- R2: With `full_duplex` high, every qualifying tick yields `start_tx` in the next cycle, regardless of carrier and slot counter.
- R3: In half-duplex mode, a qualifying tick with `carrier` high reloads the slot counter to slot_ms/10 (integer division) and does not start transmission.
- R4: In half-duplex mode with carrier clear, a qualifying tick that finds the counter above 1 decrements it by one and does not start transmission.
- R5: In half-duplex mode with carrier clear, a qualifying tick that finds the counter at 1 or 0 reloads it to slot_ms/10 and draws a byte. `start_tx` follows in the next cycle only if the byte is less than or equal to the persistence value.
- R6: After synchronous reset, the slot time is 100 ms, the persistence is 64, the slot counter holds 10 and `start_tx` is low.
- R7: A cycle with `slot_wr` high stores `slot_wdata` as the slot time and loads the counter with slot_wdata/10. This load overrides any counter change from arbitration in that cycle. Arbitration in that cycle still uses the previous slot time for its own decision.
- R8: A cycle with `pers_wr` high stores `pers_wdata`, and the new value governs draws from the next cycle on.
- R9: The LFSR loads 0xACE1 in reset and shifts left every clock. The bit shifted into bit 0 is s[15]^s[13]^s[12]^s[10]. The drawn byte is the state bits [7:0] in the tick cycle.
- R10: While `enable` is low, the counter is held at slot_ms/10 and `start_tx` stays low.
- R11: A persistence of 255 starts on every counter expiry. A persistence of 0 starts only when the drawn byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enabled |
| tick | input | 1 | One-cycle arbitration pulse, every 10 ms |
| carrier | input | 1 | Carrier detected on the channel |
| frame_pending | input | 1 | At least one frame waits to be sent |
| tx_idle | input | 1 | Transmit sequencer is idle |
| full_duplex | input | 1 | Skip channel checks |
| slot_wr | input | 1 | Write strobe for the slot time |
| slot_wdata | input | SLOT_W | New slot time in ms |
| pers_wr | input | 1 | Write strobe for the persistence |
| pers_wdata | input | 8 | New persistence value, 0..255 |
| start_tx | output | 1 | One-cycle start-transmit pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit slot time, the 0xACE1 seed, and the 100 ms / 64 reset values. With these, slot times from 0 up to 1023 ms can be written. This reaches both the reload-of-zero case, where a sub-10 ms slot gives a draw on every tick, and multi-tick countdowns. Because the seed is the default, the bench's own LFSR model predicts every drawn byte. That lets a cycle-exact comparison cover the persistence thresholds 0, 64, 128 and 255 over long runs of draws.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DUPLEX,
        ACT_DEFER,
        ACT_COUNT,
        ACT_DRAW
    } act_e;

    typedef struct packed {
        logic tick;
        logic enable;
        logic tx_idle;
        logic pending;
        logic duplex;
        logic carrier;
    } chan_in_t;

    function automatic logic [15:0] ticks_of(input logic [15:0] ms);
        return ms / 16'd10;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/ppa_lfsr.sv
module ppa_lfsr #(
    parameter logic [15:0] SEED = ppa_pkg::LFSR_SEED_DEF
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] rnd_byte
);
    logic [15:0] state;

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= ppa_pkg::lfsr_step(state);
    end

    assign rnd_byte = state[7:0];
endmodule

// File: rtl/ppa_cfg.sv
module ppa_cfg #(
    parameter int SLOT_W   = 10,
    parameter int DEF_SLOT = 100,
    parameter int DEF_PERS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_wr,
    input  logic [SLOT_W-1:0] slot_wdata,
    input  logic              pers_wr,
    input  logic [7:0]        pers_wdata,
    output logic [SLOT_W-1:0] slot_cur,
    output logic [7:0]        pers_cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cur <= SLOT_W'(DEF_SLOT);
            pers_cur <= 8'(DEF_PERS);
        end else begin
            if (slot_wr) slot_cur <= slot_wdata;
            if (pers_wr) pers_cur <= pers_wdata;
        end
    end
endmodule

// File: rtl/ppa_decide.sv
module ppa_decide
    import ppa_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int RST_CNT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_in_t         cin,
    input  logic             slot_wr,
    input  logic [CNT_W-1:0] reload_cur,
    input  logic [CNT_W-1:0] reload_new,
    input  logic [7:0]       rnd_byte,
    input  logic [7:0]       pers_cur,
    output logic [CNT_W-1:0] slot_cnt,
    output logic             start_tx
);
    act_e             act;
    logic             arm;
    logic             go;
    logic [CNT_W-1:0] cnt_d;

    assign arm = cin.tick && cin.enable && cin.tx_idle && cin.pending;

    always_comb begin
        if (!arm)                  act = ACT_NONE;
        else if (cin.duplex)       act = ACT_DUPLEX;
        else if (cin.carrier)      act = ACT_DEFER;
        else if (slot_cnt > CNT_W'(1)) act = ACT_COUNT;
        else                       act = ACT_DRAW;
    end

    always_comb begin
        if (slot_wr)          cnt_d = reload_new;
        else if (!cin.enable) cnt_d = reload_cur;
        else begin
            case (act)
                ACT_DEFER, ACT_DRAW: cnt_d = reload_cur;
                ACT_COUNT:           cnt_d = slot_cnt - 1'b1;
                default:             cnt_d = slot_cnt;
            endcase
        end
    end

    assign go = (act == ACT_DUPLEX) || ((act == ACT_DRAW) && (rnd_byte <= pers_cur));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= CNT_W'(RST_CNT);
            start_tx <= 1'b0;
        end else begin
            slot_cnt <= cnt_d;
            start_tx <= go;
        end
    end
endmodule

// File: rtl/ppa_arbiter.sv
module ppa_arbiter
    import ppa_pkg::*;
#(
    parameter int          SLOT_W   = 10,
    parameter int          DEF_SLOT = 100,
    parameter int          DEF_PERS = 64,
    parameter logic [15:0] SEED     = LFSR_SEED_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              tick,
    input  logic              carrier,
    input  logic              frame_pending,
    input  logic              tx_idle,
    input  logic              full_duplex,
    input  logic              slot_wr,
    input  logic [SLOT_W-1:0] slot_wdata,
    input  logic              pers_wr,
    input  logic [7:0]        pers_wdata,
    output logic              start_tx
);
    localparam int CNT_W   = $clog2((2 ** SLOT_W - 1) / 10 + 1);
    localparam int RST_CNT = DEF_SLOT / 10;

    logic [SLOT_W-1:0] slot_cur;
    logic [7:0]        pers_cur;
    logic [7:0]        rnd_byte;
    logic [CNT_W-1:0]  slot_cnt;
    logic [CNT_W-1:0]  reload_cur;
    logic [CNT_W-1:0]  reload_new;
    chan_in_t          cin;

    assign reload_cur = CNT_W'(ticks_of(16'(slot_cur)));
    assign reload_new = CNT_W'(ticks_of(16'(slot_wdata)));

    assign cin = '{tick: tick, enable: enable, tx_idle: tx_idle,
                   pending: frame_pending, duplex: full_duplex, carrier: carrier};

    ppa_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .rnd_byte(rnd_byte)
    );

    ppa_cfg #(.SLOT_W(SLOT_W), .DEF_SLOT(DEF_SLOT), .DEF_PERS(DEF_PERS)) u_cfg (
        .clk(clk), .rst(rst),
        .slot_wr(slot_wr), .slot_wdata(slot_wdata),
        .pers_wr(pers_wr), .pers_wdata(pers_wdata),
        .slot_cur(slot_cur), .pers_cur(pers_cur)
    );

    ppa_decide #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) u_decide (
        .clk(clk), .rst(rst), .cin(cin), .slot_wr(slot_wr),
        .reload_cur(reload_cur), .reload_new(reload_new),
        .rnd_byte(rnd_byte), .pers_cur(pers_cur),
        .slot_cnt(slot_cnt), .start_tx(start_tx)
    );
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
    parameter int SLOT_W = 10,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              tick,
    input logic              carrier,
    input logic              frame_pending,
    input logic              tx_idle,
    input logic              full_duplex,
    input logic              slot_wr,
    input logic [SLOT_W-1:0] slot_wdata,
    input logic              start_tx,
    input logic [CNT_W-1:0]  slot_cnt,
    input logic [SLOT_W-1:0] slot_cur
);
    logic armed;
    assign armed = tick && enable && tx_idle && frame_pending;

    assert_start_cause_R1: assert property (@(posedge clk) disable iff (rst)
        start_tx |-> $past(armed));

    assert_duplex_go_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && full_duplex) |=> start_tx);

    assert_carrier_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !full_duplex && carrier && !slot_wr)
        |=> (!start_tx && slot_cnt == CNT_W'($past(slot_cur) / 10)));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && !full_duplex && !carrier && slot_cnt > CNT_W'(1) && !slot_wr)
        |=> (!start_tx && slot_cnt == $past(slot_cnt) - 1'b1));

    assert_draw_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && !full_duplex && !carrier && slot_cnt <= CNT_W'(1) && !slot_wr)
        |=> (slot_cnt == CNT_W'($past(slot_cur) / 10)));

    assert_slot_reload_R7: assert property (@(posedge clk) disable iff (rst)
        slot_wr |=> (slot_cnt == CNT_W'($past(slot_wdata) / 10)));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !start_tx);
endmodule

bind ppa_arbiter ppa_checker #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .carrier(carrier),
    .frame_pending(frame_pending), .tx_idle(tx_idle), .full_duplex(full_duplex),
    .slot_wr(slot_wr), .slot_wdata(slot_wdata), .start_tx(start_tx),
    .slot_cnt(slot_cnt), .slot_cur(slot_cur)
);

// File: tb/sim_ppa_arbiter.sv
module sim_ppa_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT_W     = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, tick = 1'b0, carrier = 1'b0, frame_pending = 1'b0;
    logic tx_idle = 1'b1, full_duplex = 1'b0, slot_wr = 1'b0, pers_wr = 1'b0;
    logic [SLOT_W-1:0] slot_wdata = '0;
    logic [7:0] pers_wdata = '0;
    logic start_tx;

    int total = 0;
    int bad = 0;
    int starts = 0;
    string cur_req = "R6";
    bit done = 1'b0;

    // behavioural reference state
    int m_lfsr, m_cnt, m_slot, m_pers;
    bit m_start;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ppa_arbiter u0 (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .carrier(carrier),
        .frame_pending(frame_pending), .tx_idle(tx_idle), .full_duplex(full_duplex),
        .slot_wr(slot_wr), .slot_wdata(slot_wdata), .pers_wr(pers_wr),
        .pers_wdata(pers_wdata), .start_tx(start_tx)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_lfsr = 16'hACE1; m_cnt = 10; m_slot = 100; m_pers = 64; m_start = 0;
        end else begin
            int rnd, ncnt, fb;
            bit nstart;
            rnd = m_lfsr % 256;
            nstart = 0;
            ncnt = m_cnt;
            if (tick && enable && tx_idle && frame_pending) begin
                if (full_duplex) nstart = 1;
                else if (carrier) ncnt = m_slot / 10;
                else if (m_cnt > 1) ncnt = m_cnt - 1;
                else begin
                    ncnt = m_slot / 10;
                    if (rnd <= m_pers) nstart = 1;
                end
            end
            if (!enable) ncnt = m_slot / 10;
            if (slot_wr) ncnt = int'(slot_wdata) / 10;
            if (slot_wr) m_slot = int'(slot_wdata);
            if (pers_wr) m_pers = int'(pers_wdata);
            m_start = nstart;
            m_cnt = ncnt;
            fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
            m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (start_tx) starts++;
            if (start_tx !== m_start) begin
                bad++;
                $display("FAIL %s start_tx actual=%0b expected=%0b at %0t",
                         cur_req, start_tx, m_start, $time);
            end
        end
    end

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_slot(input int ms);
        slot_wdata = SLOT_W'(ms);
        slot_wr = 1'b1;
        @(negedge clk);
        slot_wr = 1'b0;
    endtask

    task automatic write_pers(input int p);
        pers_wdata = 8'(p);
        pers_wr = 1'b1;
        @(negedge clk);
        pers_wr = 1'b0;
    endtask

    task automatic expect_starts(input string req, input int got, input int lo, input int hi);
        total++;
        if (got < lo || got > hi) begin
            bad++;
            $display("FAIL %s start count actual=%0d expected=%0d..%0d", req, got, lo, hi);
        end
    endtask

    initial begin
        int s0;
        // R6: reset state
        cur_req = "R6";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (start_tx !== 1'b0) begin
            bad++;
            $display("FAIL R6 start_tx after reset actual=%0b expected=0", start_tx);
        end

        // R1: ticks without pending, without idle, give nothing
        cur_req = "R1";
        enable = 1'b1;
        s0 = starts;
        run_ticks(15);
        frame_pending = 1'b1; tx_idle = 1'b0;
        run_ticks(15);
        expect_starts("R1", starts - s0, 0, 0);

        // R10: disabled port stays quiet and holds its counter
        cur_req = "R10";
        tx_idle = 1'b1; enable = 1'b0;
        s0 = starts;
        run_ticks(20);
        expect_starts("R10", starts - s0, 0, 0);
        enable = 1'b1;

        // R2: full duplex starts on every tick, carrier ignored
        cur_req = "R2";
        full_duplex = 1'b1; carrier = 1'b1;
        s0 = starts;
        run_ticks(8);
        expect_starts("R2", starts - s0, 8, 8);
        full_duplex = 1'b0;

        // R3: carrier defers indefinitely
        cur_req = "R3";
        s0 = starts;
        run_ticks(30);
        expect_starts("R3", starts - s0, 0, 0);
        carrier = 1'b0;

        // R4 and R11: persistence 255, counter 10 -> start on 10th tick
        cur_req = "R4";
        write_pers(255);
        s0 = starts;
        run_ticks(9);
        expect_starts("R4", starts - s0, 0, 0);
        cur_req = "R11";
        run_ticks(1);
        expect_starts("R11", starts - s0, 1, 1);

        // R7: slot write mid-count reloads immediately
        cur_req = "R7";
        run_ticks(4);
        write_slot(30);
        s0 = starts;
        run_ticks(2);
        expect_starts("R7", starts - s0, 0, 0);
        run_ticks(1);
        expect_starts("R7", starts - s0, 1, 1);
        tick = 1'b1; slot_wdata = SLOT_W'(50); slot_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; slot_wr = 1'b0;
        run_ticks(12);

        // R11: persistence 0 with slot below 10 ms -> draw every tick
        cur_req = "R11";
        write_slot(5);
        write_pers(0);
        run_ticks(400);

        // R5 / R8: mid persistence, carrier bursts
        cur_req = "R5";
        write_slot(20);
        write_pers(64);
        s0 = starts;
        for (int k = 0; k < 40; k++) begin
            carrier = (k % 5 == 0);
            run_ticks(5);
        end
        carrier = 1'b0;
        expect_starts("R5", starts - s0, 1, 100);
        cur_req = "R8";
        write_pers(128);
        run_ticks(100);

        // R9: draw every tick exposes LFSR sequence
        cur_req = "R9";
        write_slot(0);
        s0 = starts;
        run_ticks(300);
        expect_starts("R9", starts - s0, 60, 240);

        // R10: disable mid-count, re-enable
        cur_req = "R10";
        write_slot(60);
        run_ticks(3);
        enable = 1'b0;
        run_ticks(5);
        enable = 1'b1;
        write_pers(255);
        s0 = starts;
        run_ticks(5);
        expect_starts("R10", starts - s0, 0, 0);
        run_ticks(1);
        expect_starts("R10", starts - s0, 1, 1);

        // R1: busy transmitter blocks arbitration
        cur_req = "R1";
        tx_idle = 1'b0;
        s0 = starts;
        run_ticks(20);
        expect_starts("R1", starts - s0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule